// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block converts a three-level PWM command (drive high, drive low, or undriven) into two gate enables for a synchronous buck stage. One enable is for the high-side switch and one is for the low-side switch. The block never lets the two enables overlap.

Dead time is adaptive:
- Before the high-side gate turns on, the block waits for the low-side gate's discharge comparator.
- Before the low-side gate turns on, the block waits for the high-side discharge comparator and the switch-node-low comparator.
- A timeout stops the sequencer from stalling when a comparator never reports.

An undriven PWM level has to persist through a hold-off window before both gates are released. When a valid level returns after that, it has to hold steady for an exit delay before switching resumes.

In diode-emulation mode the low-side gate has a minimum on-time. Once that time has passed, the gate turns off when the zero-cross flag reports reverse current. Every delay is a parameter counted in clock cycles. All comparator inputs are assumed to be synchronous to `clk`. No data flows through this block, so every pin is a plain control or status level with no handshake.

Top module: `hb_gate_seq`

## Requirements
- R1: After a high command, the low-side enable drops first. The high-side enable rises only after at least one cycle with both enables low, and only once `ls_gate_low` is sampled high or the timeout expires.
- R2: After a low command, the high-side enable drops first. The low-side enable rises only after at least one cycle with both enables low, and only once `hs_gate_low` and `sw_node_low` are both sampled high or the timeout expires.
- R3: `gh_en` and `gl_en` are never high in the same cycle, whatever the input sequence.
- R4: An undriven level (`pwm_lvl[1]`=1) releases both gates only after it has been sampled on HOLD_CYC consecutive edges. The gates are low on the edge after that. A shorter excursion changes neither enable.
- R5: After the gates have been released, a driven level takes effect only once the same level has been sampled on EXIT_CYC consecutive edges. While both gates are active, a change between high and low takes effect on the next edge.
- R6: In diode-emulation mode (`dcm_mode`=1), the low-side enable stays high for at least MIN_ON_CYC cycles. Once that has elapsed, it drops on the edge that samples `zc_rev`=1, and both enables then stay low until a high command arrives.
- R7: In continuous mode (`dcm_mode`=0), `zc_rev` has no effect: the low-side enable stays high for as long as the low command lasts. Switching to continuous mode while in the emulated-diode off state turns the low side back on through the R2 sequence.
- R8: The high-side sequencing of R1 is the same in both modes.
- R9: If the awaited discharge flags are not seen, the waiting gate turns on TMO_CYC edges after the wait began.
- R10: `en`=0 forces both enables low in the same cycle and returns the sequencer to idle. With `en`=1 again, switching resumes only through the R5 exit delay.
- R11: The `pwm_lvl` encoding is: 2'b01 means drive high, 2'b00 means drive low, and 2'b10 or 2'b11 means undriven.
- R12: After reset both enables are low, and the first command is treated as an exit from the undriven state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces both gates off and idles the sequencer |
| pwm_lvl | input | 2 | Decoded PWM level, encoded as in R11 |
| dcm_mode | input | 1 | 1 = diode emulation, 0 = continuous conduction |
| ls_gate_low | input | 1 | Low-side gate below its discharge threshold |
| hs_gate_low | input | 1 | High-side gate below its discharge threshold |
| sw_node_low | input | 1 | Switch node below about 1 V |
| zc_rev | input | 1 | Zero-cross comparator reports reverse inductor current |
| gh_en | output | 1 | High-side gate enable |
| gl_en | output | 1 | Low-side gate enable |

## Verification
The assertions assume that every comparator flag and the PWM level are already synchronised to `clk` and change only between edges. The timeout is what bounds the dead time, so the assertions make no assumption that the flags ever arrive. The stimulus changes all inputs on the falling edge and holds each PWM level for a random run length. Undriven runs are drawn both shorter and longer than the hold-off window, and discharge flags are sometimes held low so that the timeout path is exercised. Directed sequences cover:
- the exact cycles of hold-off, exit delay, timeout and minimum on-time;
- the enable cut-off.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_LOW  = 2'd1,
    CMD_HIGH = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HS = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_WAIT_LS = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_DE_OFF  = 3'd5
  } seq_st_e;

  // Level encoding: bit1 set = undriven, else bit0 selects high/low.
  function automatic cmd_e decode_lvl(input logic [1:0] lvl);
    if (lvl[1])      return CMD_OFF;
    else if (lvl[0]) return CMD_HIGH;
    else             return CMD_LOW;
  endfunction

endpackage

// File: rtl/hbs_tri_filter.sv
module hbs_tri_filter
  import hbs_pkg::*;
#(
  parameter int HOLD_CYC = 35,
  parameter int EXIT_CYC = 7,
  parameter int CW       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_lvl,
  output cmd_e       cmd
);

  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] EXIT_END  = CW'(EXIT_CYC);
  localparam logic [CW-1:0] ONE       = CW'(1);

  cmd_e          raw, raw_q;
  logic [CW-1:0] tri_cnt, exit_cnt, exit_nxt;

  always_comb begin
    raw      = decode_lvl(pwm_lvl);
    exit_nxt = (raw == raw_q) ? exit_cnt + ONE : ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd      <= CMD_OFF;
      raw_q    <= CMD_OFF;
      tri_cnt  <= '0;
      exit_cnt <= '0;
    end else if (!en) begin
      cmd      <= CMD_OFF;
      raw_q    <= CMD_OFF;
      tri_cnt  <= '0;
      exit_cnt <= '0;
    end else begin
      raw_q <= raw;
      if (raw == CMD_OFF) begin
        exit_cnt <= '0;
        if (cmd == CMD_OFF) begin
          tri_cnt <= '0;
        end else if (tri_cnt == HOLD_LAST) begin
          cmd     <= CMD_OFF;
          tri_cnt <= '0;
        end else begin
          tri_cnt <= tri_cnt + ONE;
        end
      end else begin
        tri_cnt <= '0;
        if (cmd != CMD_OFF) begin
          cmd      <= raw;
          exit_cnt <= '0;
        end else if (exit_nxt == EXIT_END) begin
          cmd      <= raw;
          exit_cnt <= '0;
        end else begin
          exit_cnt <= exit_nxt;
        end
      end
    end
  end

  // R4: the command can only be released after an undriven sample.
  assert_tri_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && en && $past(cmd) != CMD_OFF && cmd == CMD_OFF) |-> $past(pwm_lvl[1]))
    else $error("tri release without undriven input");

  // R5: leaving the released state follows a driven sample of the same level.
  assert_exit_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd) == CMD_OFF && cmd != CMD_OFF) |-> (!$past(pwm_lvl[1]) && (cmd == decode_lvl($past(pwm_lvl)))))
    else $error("exit with wrong level");

endmodule

// File: rtl/hbs_fsm.sv
module hbs_fsm
  import hbs_pkg::*;
#(
  parameter int MIN_ON_CYC = 70,
  parameter int TMO_CYC    = 40,
  parameter int CW         = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dcm_mode,
  input  cmd_e cmd,
  input  logic ls_gate_low,
  input  logic hs_gate_low,
  input  logic sw_node_low,
  input  logic zc_rev,
  output logic gh_en,
  output logic gl_en
);

  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(MIN_ON_CYC - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  seq_st_e       st, st_n;
  logic [CW-1:0] wait_cnt, on_cnt;
  logic          tmo_hit, min_done, hs_clear, ls_clear;

  always_comb begin
    tmo_hit  = (wait_cnt == TMO_LAST);
    min_done = (on_cnt == ON_LAST);
    hs_clear = hs_gate_low && sw_node_low;
    ls_clear = ls_gate_low;
  end

  always_comb begin
    st_n = st;
    unique case (st)
      ST_IDLE: begin
        if (cmd == CMD_HIGH)     st_n = ST_WAIT_HS;
        else if (cmd == CMD_LOW) st_n = ST_WAIT_LS;
      end
      ST_WAIT_HS: begin
        if (cmd == CMD_OFF)          st_n = ST_IDLE;
        else if (cmd == CMD_LOW)     st_n = ST_WAIT_LS;
        else if (ls_clear || tmo_hit) st_n = ST_HS_ON;
      end
      ST_HS_ON: begin
        if (cmd == CMD_OFF)      st_n = ST_IDLE;
        else if (cmd == CMD_LOW) st_n = ST_WAIT_LS;
      end
      ST_WAIT_LS: begin
        if (cmd == CMD_OFF)           st_n = ST_IDLE;
        else if (cmd == CMD_HIGH)     st_n = ST_WAIT_HS;
        else if (hs_clear || tmo_hit) st_n = ST_LS_ON;
      end
      ST_LS_ON: begin
        if (cmd == CMD_OFF)                        st_n = ST_IDLE;
        else if (cmd == CMD_HIGH)                  st_n = ST_WAIT_HS;
        else if (dcm_mode && min_done && zc_rev)   st_n = ST_DE_OFF;
      end
      ST_DE_OFF: begin
        if (cmd == CMD_OFF)       st_n = ST_IDLE;
        else if (cmd == CMD_HIGH) st_n = ST_WAIT_HS;
        else if (!dcm_mode)       st_n = ST_WAIT_LS;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      on_cnt   <= '0;
    end else if (!en) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      on_cnt   <= '0;
    end else begin
      st <= st_n;
      if (st_n != st)
        wait_cnt <= '0;
      else if (st == ST_WAIT_HS || st == ST_WAIT_LS)
        wait_cnt <= wait_cnt + ONE;
      if (st_n == ST_LS_ON && st != ST_LS_ON)
        on_cnt <= '0;
      else if (st == ST_LS_ON && !min_done)
        on_cnt <= on_cnt + ONE;
    end
  end

  assign gh_en = en && (st == ST_HS_ON);
  assign gl_en = en && (st == ST_LS_ON);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(gh_en && gl_en))
    else $error("both gates enabled");

  assert_hs_dead_time_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gh_en) |-> !$past(gl_en))
    else $error("high side rose straight from low side");

  assert_ls_dead_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_en) |-> !$past(gh_en))
    else $error("low side rose straight from high side");

  assert_resume_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && en) |-> (!gh_en && !gl_en))
    else $error("gate on right after enable");

  assert_de_turnoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gl_en) && !gl_en && en && $past(en) && $past(cmd) == CMD_LOW)
      |-> ($past(dcm_mode) && $past(zc_rev) && $past(min_done)))
    else $error("low side dropped early");

  assert_ccm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gl_en) && !$past(dcm_mode) && $past(cmd) == CMD_LOW && en) |-> gl_en)
    else $error("low side dropped in continuous mode");

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hbs_pkg::*;
#(
  parameter int HOLD_CYC   = 35,
  parameter int EXIT_CYC   = 7,
  parameter int MIN_ON_CYC = 70,
  parameter int TMO_CYC    = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_lvl,
  input  logic       dcm_mode,
  input  logic       ls_gate_low,
  input  logic       hs_gate_low,
  input  logic       sw_node_low,
  input  logic       zc_rev,
  output logic       gh_en,
  output logic       gl_en
);

  localparam int FILT_MAX = (HOLD_CYC > EXIT_CYC) ? HOLD_CYC : EXIT_CYC;
  localparam int SEQ_MAX  = (MIN_ON_CYC > TMO_CYC) ? MIN_ON_CYC : TMO_CYC;
  localparam int FILT_W   = $clog2(FILT_MAX + 1);
  localparam int SEQ_W    = $clog2(SEQ_MAX + 1);

  cmd_e cmd;

  hbs_tri_filter #(
    .HOLD_CYC (HOLD_CYC),
    .EXIT_CYC (EXIT_CYC),
    .CW       (FILT_W)
  ) u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .pwm_lvl (pwm_lvl),
    .cmd     (cmd)
  );

  hbs_fsm #(
    .MIN_ON_CYC (MIN_ON_CYC),
    .TMO_CYC    (TMO_CYC),
    .CW         (SEQ_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .dcm_mode    (dcm_mode),
    .cmd         (cmd),
    .ls_gate_low (ls_gate_low),
    .hs_gate_low (hs_gate_low),
    .sw_node_low (sw_node_low),
    .zc_rev      (zc_rev),
    .gh_en       (gh_en),
    .gl_en       (gl_en)
  );

endmodule

// File: tb/hb_gate_seq_bench.sv
`timescale 1ns/1ps
module hb_gate_seq_bench;

  localparam int HOLD = 6;
  localparam int EXITC = 3;
  localparam int MINON = 5;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] pwm_lvl = 2'b10;
  logic dcm_mode = 1'b0;
  logic ls_gate_low = 1'b1, hs_gate_low = 1'b1, sw_node_low = 1'b1, zc_rev = 1'b0;
  logic gh_en, gl_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R12";

  // reference state: cmd 0 off / 1 low / 2 high; phase 0 idle,1 wait-hs,2 hs,3 wait-ls,4 ls,5 diode-off
  int r_cmd, r_prevraw, r_tri, r_exit, r_phase, r_wait, r_on;

  always #2 clk = ~clk;

  hb_gate_seq #(
    .HOLD_CYC(HOLD), .EXIT_CYC(EXITC), .MIN_ON_CYC(MINON), .TMO_CYC(TMO)
  ) u_hb_gate_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_lvl(pwm_lvl), .dcm_mode(dcm_mode),
    .ls_gate_low(ls_gate_low), .hs_gate_low(hs_gate_low), .sw_node_low(sw_node_low),
    .zc_rev(zc_rev), .gh_en(gh_en), .gl_en(gl_en)
  );

  // R11 encoding
  function automatic int lvl_to_cmd(input logic [1:0] l);
    if (l[1]) return 0;
    return l[0] ? 2 : 1;
  endfunction

  function automatic bit exp_gh();
    return en && (r_phase == 2);
  endfunction

  function automatic bit exp_gl();
    return en && (r_phase == 4);
  endfunction

  task automatic ref_clear();
    r_cmd = 0; r_prevraw = 0; r_tri = 0; r_exit = 0;
    r_phase = 0; r_wait = 0; r_on = 0;
  endtask

  task automatic ref_edge();
    int raw, nph, ncnt;
    if (!rst_n || !en) begin
      ref_clear();
      return;
    end
    raw = lvl_to_cmd(pwm_lvl);
    nph = r_phase;
    if (r_cmd == 0 && r_phase != 0) nph = 0;
    else if (r_phase == 0) nph = (r_cmd == 2) ? 1 : (r_cmd == 1) ? 3 : 0;
    else if (r_cmd == 2 && r_phase != 1 && r_phase != 2) nph = 1;
    else if (r_cmd == 1 && (r_phase == 1 || r_phase == 2)) nph = 3;
    else if (r_phase == 1 && (ls_gate_low || r_wait == TMO - 1)) nph = 2;
    else if (r_phase == 3 && ((hs_gate_low && sw_node_low) || r_wait == TMO - 1)) nph = 4;
    else if (r_phase == 4 && dcm_mode && zc_rev && r_on >= MINON - 1) nph = 5;
    else if (r_phase == 5 && !dcm_mode) nph = 3;
    if (nph != r_phase) r_wait = 0;
    else if (r_phase == 1 || r_phase == 3) r_wait++;
    if (nph == 4 && r_phase != 4) r_on = 0;
    else if (r_phase == 4 && r_on < MINON - 1) r_on++;
    r_phase = nph;
    // filter
    if (raw == 0) begin
      r_exit = 0;
      if (r_cmd == 0) r_tri = 0;
      else if (r_tri + 1 == HOLD) begin r_cmd = 0; r_tri = 0; end
      else r_tri++;
    end else begin
      r_tri = 0;
      if (r_cmd != 0) begin r_cmd = raw; r_exit = 0; end
      else begin
        ncnt = (raw == r_prevraw) ? r_exit + 1 : 1;
        if (ncnt == EXITC) begin r_cmd = raw; r_exit = 0; end
        else r_exit = ncnt;
      end
    end
    r_prevraw = raw;
  endtask

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // one clock: edge, reference update, compare away from the edge
  task automatic tick();
    @(posedge clk);
    ref_edge();
    @(negedge clk);
    chk(cur_req, "gh_en vs model", gh_en, exp_gh());
    chk(cur_req, "gl_en vs model", gl_en, exp_gl());
    chk("R3", "overlap", gh_en & gl_en, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic flags_ok();
    ls_gate_low = 1; hs_gate_low = 1; sw_node_low = 1;
  endtask

  initial begin
    ref_clear();
    repeat (3) @(negedge clk);
    cur_req = "R12";
    chk("R12", "gh after reset", gh_en, 0);
    chk("R12", "gl after reset", gl_en, 0);
    rst_n = 1; en = 1;

    // R5 exit delay / R12 start-up: high held, flags clear
    cur_req = "R5"; flags_ok(); pwm_lvl = 2'b01;
    ticks(EXITC + 1);
    chk("R5", "gh before exit delay done", gh_en, 0);
    tick();
    chk("R5", "gh after exit + wait", gh_en, 1);
    ticks(4);

    // R4 short excursion ignored
    cur_req = "R4"; pwm_lvl = 2'b10;
    ticks(HOLD - 1);
    pwm_lvl = 2'b01;
    ticks(3);
    chk("R4", "gh kept through short undriven", gh_en, 1);
    // R4 long excursion releases
    pwm_lvl = 2'b11;
    ticks(HOLD);
    chk("R4", "gh still on at hold edge", gh_en, 1);
    tick();
    chk("R4", "gh released after hold", gh_en, 0);
    pwm_lvl = 2'b01; ticks(EXITC + 4);

    // R9 / R2 timeout on low side wait
    cur_req = "R9"; hs_gate_low = 0; pwm_lvl = 2'b00;
    ticks(1 + TMO);
    chk("R9", "gl before timeout", gl_en, 0);
    chk("R2", "gh off while waiting", gh_en, 0);
    tick();
    chk("R9", "gl on at timeout", gl_en, 1);
    flags_ok();

    // R7 continuous mode ignores zero-cross
    cur_req = "R7"; zc_rev = 1; dcm_mode = 0;
    ticks(20);
    chk("R7", "gl held with zc in continuous", gl_en, 1);

    // R6 diode emulation minimum on-time
    cur_req = "R6"; zc_rev = 0; pwm_lvl = 2'b01; ticks(4);
    dcm_mode = 1; zc_rev = 1; pwm_lvl = 2'b00;
    ticks(2 + MINON);
    chk("R6", "gl held for minimum on-time", gl_en, 1);
    tick();
    chk("R6", "gl off at zero cross", gl_en, 0);
    ticks(3);
    chk("R6", "gl stays off in diode state", gl_en, 0);
    cur_req = "R7"; dcm_mode = 0; ticks(3);
    chk("R7", "gl back on in continuous", gl_en, 1);

    // R8 / R1 high side same in emulation mode, with low-side flag late
    cur_req = "R8"; dcm_mode = 1; zc_rev = 0; ls_gate_low = 0; pwm_lvl = 2'b01;
    ticks(2);
    chk("R1", "gl off first", gl_en, 0);
    chk("R1", "gh waits for ls flag", gh_en, 0);
    ls_gate_low = 1; ticks(1);
    chk("R8", "gh on in emulation mode", gh_en, 1);

    // R10 enable cut
    cur_req = "R10"; en = 0; #1;
    chk("R10", "gh cut immediately", gh_en, 0);
    ticks(2);
    en = 1; ticks(EXITC + 1);
    chk("R10", "gh waits exit delay after enable", gh_en, 0);
    ticks(1);
    chk("R10", "gh resumes", gh_en, 1);

    // random phase
    cur_req = "R3";
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 600; seg++) begin
      int kind, len;
      kind = $urandom_range(0, 9);
      if (kind < 4) begin pwm_lvl = 2'b01; len = $urandom_range(1, 20); cur_req = "R1"; end
      else if (kind < 8) begin pwm_lvl = 2'b00; len = $urandom_range(1, 20); cur_req = "R2"; end
      else begin
        pwm_lvl = {1'b1, 1'($urandom_range(0, 1))};
        len = ($urandom_range(0, 1) == 1) ? $urandom_range(1, HOLD - 1) : $urandom_range(HOLD, HOLD + 8);
        cur_req = "R4";
      end
      if ($urandom_range(0, 7) == 0) dcm_mode = ~dcm_mode;
      for (int c = 0; c < len; c++) begin
        bit stuck;
        stuck = ($urandom_range(0, 5) == 0);
        ls_gate_low = stuck ? 1'b0 : 1'($urandom_range(0, 3) != 0);
        hs_gate_low = stuck ? 1'b0 : 1'($urandom_range(0, 3) != 0);
        sw_node_low = 1'($urandom_range(0, 4) != 0);
        zc_rev      = 1'($urandom_range(0, 2) == 0);
        en          = ($urandom_range(0, 60) != 0);
        if (!en) begin
          #1;
          chk("R10", "gates off with enable low", gh_en | gl_en, 0);
        end
        tick();
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule